// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Line-Status Flags

The block takes an asynchronous serial line and recovers one character at a time. It samples the line sixteen times per bit, using a strobe from an external rate generator. Each frame has a low start bit, eight data bits sent least significant bit first, a parity bit, a wake-up bit and a high stop bit. A completed character goes into a receive data register. The block also keeps five sticky status flags, which software clears by writing ones to them. The flags record a character being available, a framing error, a break on the line, an ASCII control character, and a wake-up address match selected by a mask.

A break is a frame in which every bit after the start bit is zero. It is reported twice. The first report comes as soon as the all-zero frame is recognised. The second comes when the line goes high again, and at that point a zero byte is loaded as the received character. A single interrupt request is the OR of all flags that are both set and enabled. When receive DMA is on, the block asks for a transfer whenever a character is waiting. In that mode the character-available interrupt is passed on only while the DMA end-of-process input is high.

The deserialiser is a state machine with these states:
- `RX_IDLE`: waits for the line to go low, then goes to `RX_START`.
- `RX_START`: checks the line at mid-bit. If the line is low it goes to `RX_SHIFT`; if the line is high it treats the pulse as a glitch and returns to `RX_IDLE`.
- `RX_SHIFT`: collects ten payload bits, one every sixteen strobes, then goes to `RX_STOP`.
- `RX_STOP`: samples the stop bit and then takes one of three paths:
  - stop bit high: goes to `RX_IDLE`.
  - stop bit low and the payload all zero: goes to `RX_BREAK`.
  - stop bit low and the payload not all zero (framing error): goes to `RX_RESYNC`.
- `RX_BREAK` and `RX_RESYNC`: both wait for the line to go high, then go to `RX_IDLE`. Leaving `RX_BREAK` also signals the end of the break.

Top module: `serial_rx_flags`

## Requirements
- R1: The line passes through a two-flop synchroniser. A start bit is accepted only if the line is still low on the 8th strobe after the falling edge. A shorter low pulse produces no character. After a start bit is accepted, 8 data bits (LSB first), a parity bit, a wake-up bit and a stop bit are each sampled 16 strobes apart. A completed character loads `rx_data` and sets `flags[0]` (character available).
- R2: If the stop bit is low and at least one earlier payload bit is 1, `flags[1]` (framing error) is set. The receiver then waits for the line to go high before it looks for the next start bit.
- R3: Flags bit layout: [0] available, [1] framing error, [2] break, [3] control character, [4] wake-up. A flag stays set until a write with `wr_sel`=0 has a 1 in its bit position. A 0 in that position leaves the flag unchanged.
- R4: A frame whose data, parity, wake-up and stop bits are all 0 sets `flags[2]` as soon as its stop bit is sampled. It does not set `flags[1]` or `flags[0]`, and it leaves `rx_data` unchanged.
- R5: When the line goes high after a break, `rx_data` becomes 0 and `flags[2]` is set again together with `flags[0]`.
- R6: `flags[3]` is set when a loaded character has both bit 5 and bit 6 equal to 0. This includes the zero byte loaded at the end of a break.
- R7: `flags[4]` is set when a character's wake-up bit is 1 and the character equals `wake_match` in every bit where `wake_mask` is 1.
- R8: A write with `wr_sel`=1 loads the enable register, with this bit layout: [0] available interrupt, [1] receive DMA, [2] framing-error interrupt, [3] break interrupt, [4] control-character interrupt, [5] wake-up interrupt. `irq` is high while any flag is set and its interrupt bit is enabled. When DMA is enabled, the available flag drives `irq` only while `dma_eop` is high.
- R9: `dma_req` is high exactly when receive DMA is enabled and `flags[0]` is set.
- R10: If a flag is set in the same cycle that a write clears it, the flag ends up set.
- R11: After reset, the flags, the enable register and `rx_data` are all zero, and `irq` and `dma_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Asynchronous serial line, high when idle |
| os_tick | input | 1 | Sampling strobe at sixteen times the bit rate |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: clear flags by writing ones, 1: load the enable register |
| wr_data | input | 6 | Write data |
| wake_match | input | 8 | Wake-up address to compare against |
| wake_mask | input | 8 | Bits of the wake-up address that take part in the compare |
| dma_eop | input | 1 | DMA end-of-process indication |
| rx_data | output | 8 | Receive data register |
| flags | output | 5 | Sticky status flags |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Receive DMA request |

## Verification
The assertions check several rules on every cycle:
- A flag stays set unless a write clears it, and a write of 1 clears it.
- A set and a clear in the same cycle leave the flag set.
- A framing error marks its flag.
- The start of a break sets the break flag and leaves the data register unchanged; the end of a break loads zero.
- `dma_req` stays low while DMA is disabled.
- `irq` stays low in DMA mode when end-of-process is absent and no other flag is set.

Other behaviour shows only in the bench's scenarios, because it depends on whole frames at the line:
- bit order and sampling position;
- rejection of a short start glitch;
- recovery after a framing error;
- the control-character and masked wake-up decodes;
- the double interrupt of a break.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_SHIFT,
        RX_STOP,
        RX_BREAK,
        RX_RESYNC
    } rx_state_e;

    // status flag positions
    localparam int FLG_AVAIL = 0;
    localparam int FLG_FERR  = 1;
    localparam int FLG_BRK   = 2;
    localparam int FLG_CTRL  = 3;
    localparam int FLG_WAKE  = 4;
    localparam int FLG_W     = 5;

    // enable register positions
    localparam int EN_AVAIL_IE = 0;
    localparam int EN_DMA      = 1;
    localparam int EN_FERR_IE  = 2;
    localparam int EN_BRK_IE   = 3;
    localparam int EN_CTRL_IE  = 4;
    localparam int EN_WAKE_IE  = 5;
    localparam int EN_W        = 6;

    localparam logic SEL_FLAGS  = 1'b0;
    localparam logic SEL_ENABLE = 1'b1;

    // a control character has both of these bits clear
    localparam int CTRL_BIT_LO = 5;
    localparam int CTRL_BIT_HI = 6;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/srx_deser.sv
module srx_deser
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              tick,
    output logic              char_evt,
    output logic              char_ferr,
    output logic [DATA_W-1:0] char_data,
    output logic              char_wake,
    output logic              brk_start_evt,
    output logic              brk_end_evt
);

    // payload = data bits, parity bit, wake-up bit
    localparam int PAY_W = DATA_W + 2;
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(PAY_W + 1);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAY_W - 1);

    rx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [IDX_W-1:0]   idx_q;
    logic [PAY_W-1:0]   pay_q;
    logic               mid_hit;
    logic               bit_hit;
    logic               pay_zero;
    logic               stop_hit;

    assign mid_hit  = tick && (cnt_q == MID_CNT);
    assign bit_hit  = tick && (cnt_q == LAST_CNT);
    assign pay_zero = (pay_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (!line) state_d = RX_START;
            end
            RX_START: begin
                if (mid_hit) state_d = line ? RX_IDLE : RX_SHIFT;
            end
            RX_SHIFT: begin
                if (bit_hit && (idx_q == IDX_LAST)) state_d = RX_STOP;
            end
            RX_STOP: begin
                if (bit_hit) begin
                    if (line)          state_d = RX_IDLE;
                    else if (pay_zero) state_d = RX_BREAK;
                    else               state_d = RX_RESYNC;
                end
            end
            RX_BREAK, RX_RESYNC: begin
                if (line) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // strobe counter, payload index and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            pay_q <= '0;
        end else begin
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
            end

            if (state_q == RX_START) begin
                idx_q <= '0;
            end else if ((state_q == RX_SHIFT) && bit_hit) begin
                idx_q <= idx_q + 1'b1;
            end

            if ((state_q == RX_SHIFT) && bit_hit) begin
                pay_q <= {line, pay_q[PAY_W-1:1]};
            end
        end
    end

    // event outputs
    always_comb begin
        stop_hit      = (state_q == RX_STOP) && bit_hit;
        char_evt      = stop_hit && (line || !pay_zero);
        char_ferr     = !line;
        brk_start_evt = stop_hit && !line && pay_zero;
        brk_end_evt   = (state_q == RX_BREAK) && line;
    end

    assign char_data = pay_q[DATA_W-1:0];
    assign char_wake = pay_q[PAY_W-1];

endmodule

// File: rtl/srx_flags.sv
module srx_flags
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_evt,
    input  logic              char_ferr,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_wake,
    input  logic              brk_start_evt,
    input  logic              brk_end_evt,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [EN_W-1:0]   wr_data,
    input  logic [DATA_W-1:0] wake_match,
    input  logic [DATA_W-1:0] wake_mask,
    input  logic              dma_eop,
    output logic [DATA_W-1:0] rx_data,
    output logic [FLG_W-1:0]  flags,
    output logic [EN_W-1:0]   enables,
    output logic              irq,
    output logic              dma_req
);

    logic [FLG_W-1:0]  set_v;
    logic [FLG_W-1:0]  clr_v;
    logic [FLG_W-1:0]  flg_q;
    logic [EN_W-1:0]   en_q;
    logic [DATA_W-1:0] data_q;
    logic              is_ctrl;
    logic              wake_ok;
    logic              avail_req;

    always_comb begin
        is_ctrl = !char_data[CTRL_BIT_LO] && !char_data[CTRL_BIT_HI];
        wake_ok = char_wake && (((char_data ^ wake_match) & wake_mask) == '0);

        set_v            = '0;
        set_v[FLG_AVAIL] = char_evt | brk_end_evt;
        set_v[FLG_FERR]  = char_evt & char_ferr;
        set_v[FLG_BRK]   = brk_start_evt | brk_end_evt;
        set_v[FLG_CTRL]  = (char_evt & is_ctrl) | brk_end_evt;
        set_v[FLG_WAKE]  = char_evt & wake_ok;

        clr_v = (wr_en && (wr_sel == SEL_FLAGS)) ? wr_data[FLG_W-1:0] : '0;
    end

    // one sticky flop per flag; a set overrides a clear
    for (genvar i = 0; i < FLG_W; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flg_q[i] <= 1'b0;
            else        flg_q[i] <= set_v[i] | (flg_q[i] & ~clr_v[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && (wr_sel == SEL_ENABLE)) begin
            en_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (brk_end_evt) begin
            data_q <= '0;
        end else if (char_evt) begin
            data_q <= char_data;
        end
    end

    always_comb begin
        avail_req = flg_q[FLG_AVAIL] & en_q[EN_AVAIL_IE] & (!en_q[EN_DMA] | dma_eop);
        irq = avail_req
            | (flg_q[FLG_FERR] & en_q[EN_FERR_IE])
            | (flg_q[FLG_BRK]  & en_q[EN_BRK_IE])
            | (flg_q[FLG_CTRL] & en_q[EN_CTRL_IE])
            | (flg_q[FLG_WAKE] & en_q[EN_WAKE_IE]);
        dma_req = en_q[EN_DMA] & flg_q[FLG_AVAIL];
    end

    assign rx_data = data_q;
    assign flags   = flg_q;
    assign enables = en_q;

endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
    import srx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              os_tick,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [EN_W-1:0]   wr_data,
    input  logic [DATA_W-1:0] wake_match,
    input  logic [DATA_W-1:0] wake_mask,
    input  logic              dma_eop,
    output logic [DATA_W-1:0] rx_data,
    output logic [FLG_W-1:0]  flags,
    output logic              irq,
    output logic              dma_req
);

    logic              line_s;
    logic              char_evt;
    logic              char_ferr;
    logic [DATA_W-1:0] char_data;
    logic              char_wake;
    logic              brk_start_evt;
    logic              brk_end_evt;
    logic [EN_W-1:0]   ctrl_en;

    srx_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (line_s)
    );

    srx_deser #(
        .DATA_W (DATA_W),
        .OSR    (OSR)
    ) u_deser (
        .clk           (clk),
        .rst_n         (rst_n),
        .line          (line_s),
        .tick          (os_tick),
        .char_evt      (char_evt),
        .char_ferr     (char_ferr),
        .char_data     (char_data),
        .char_wake     (char_wake),
        .brk_start_evt (brk_start_evt),
        .brk_end_evt   (brk_end_evt)
    );

    srx_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .char_evt      (char_evt),
        .char_ferr     (char_ferr),
        .char_data     (char_data),
        .char_wake     (char_wake),
        .brk_start_evt (brk_start_evt),
        .brk_end_evt   (brk_end_evt),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .wake_match    (wake_match),
        .wake_mask     (wake_mask),
        .dma_eop       (dma_eop),
        .rx_data       (rx_data),
        .flags         (flags),
        .enables       (ctrl_en),
        .irq           (irq),
        .dma_req       (dma_req)
    );

endmodule

// File: rtl/srx_chk.sv
module srx_chk
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              char_evt,
    input logic              char_ferr,
    input logic              brk_start_evt,
    input logic              brk_end_evt,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [EN_W-1:0]   wr_data,
    input logic              dma_eop,
    input logic [DATA_W-1:0] rx_data,
    input logic [FLG_W-1:0]  flags,
    input logic [EN_W-1:0]   enables,
    input logic              irq,
    input logic              dma_req
);

    logic flag_wr;
    assign flag_wr = wr_en && (wr_sel == SEL_FLAGS);

    AST_FERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        char_evt && char_ferr |=> flags[FLG_FERR]); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FLG_FERR] && !(flag_wr && wr_data[FLG_FERR]) |=> flags[FLG_FERR]); // R3

    AST_W1C_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr && wr_data[FLG_BRK] && !brk_start_evt && !brk_end_evt |=> !flags[FLG_BRK]); // R3

    AST_BRK_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start_evt |=> flags[FLG_BRK] && $stable(rx_data)); // R4

    AST_BRK_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end_evt |=> flags[FLG_BRK] && flags[FLG_AVAIL] && (rx_data == '0)); // R5

    AST_DMA_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        enables[EN_DMA] && !dma_eop && (flags[FLG_W-1:1] == '0) |-> !irq); // R8

    AST_DMA_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enables[EN_DMA] |-> !dma_req); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        char_evt && flag_wr && wr_data[FLG_AVAIL] |=> flags[FLG_AVAIL]); // R10

endmodule

bind serial_rx_flags srx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .char_evt      (char_evt),
    .char_ferr     (char_ferr),
    .brk_start_evt (brk_start_evt),
    .brk_end_evt   (brk_end_evt),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .dma_eop       (dma_eop),
    .rx_data       (rx_data),
    .flags         (flags),
    .enables       (ctrl_en),
    .irq           (irq),
    .dma_req       (dma_req)
);

// File: tb/serial_rx_flags_bench.sv
module serial_rx_flags_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [5:0] wr_data = '0;
    logic [7:0] wake_match = 8'hA5;
    logic [7:0] wake_mask = 8'hF0;
    logic       dma_eop = 1'b0;
    logic [7:0] rx_data;
    logic [4:0] flags;
    logic       irq;
    logic       dma_req;

    int checks = 0;
    int fails = 0;
    logic mon_on = 1'b0;
    logic ctrl_seen = 1'b0;

    always #4 clk = ~clk;

    serial_rx_flags u_serial_rx_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd        (rxd),
        .os_tick    (os_tick),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .wake_match (wake_match),
        .wake_mask  (wake_mask),
        .dma_eop    (dma_eop),
        .rx_data    (rx_data),
        .flags      (flags),
        .irq        (irq),
        .dma_req    (dma_req)
    );

    // {data, parity, wake, stop, expected flags}; match A5, mask F0
    localparam logic [15:0] VEC [8] = '{
        {8'h41, 1'b0, 1'b0, 1'b1, 5'b00001},
        {8'h0D, 1'b0, 1'b0, 1'b1, 5'b01001},
        {8'h55, 1'b0, 1'b0, 1'b0, 5'b00011},
        {8'hA3, 1'b0, 1'b1, 1'b1, 5'b10001},
        {8'hB5, 1'b0, 1'b1, 1'b1, 5'b00001},
        {8'hA5, 1'b0, 1'b0, 1'b1, 5'b00001},
        {8'h80, 1'b1, 1'b0, 1'b1, 5'b01001},
        {8'h00, 1'b1, 1'b0, 1'b0, 5'b01011}
    };

    always @(negedge clk) begin
        if (mon_on && flags[3]) ctrl_seen <= 1'b1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [5:0] d);
        wr_sel  = sel;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic par, input logic wk,
                              input logic stp, input logic hold_low);
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (16) @(negedge clk);
        end
        rxd = par;
        repeat (16) @(negedge clk);
        rxd = wk;
        repeat (16) @(negedge clk);
        rxd = stp;
        repeat (16) @(negedge clk);
        if (!hold_low) rxd = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R11 reset state
        chk("R11 flags", flags, 5'b0);
        chk("R11 rx_data", rx_data, 8'h00);
        chk("R11 irq", irq, 1'b0);
        chk("R11 dma_req", dma_req, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // table: R1 R2 R6 R7 frame decoding
        for (int v = 0; v < 8; v++) begin
            reg_write(1'b0, 6'h1F);
            send_frame(VEC[v][15:8], VEC[v][7], VEC[v][6], VEC[v][5], 1'b0);
            repeat (8) @(negedge clk);
            chk("R1 rx_data", rx_data, VEC[v][15:8]);
            chk("R1 R2 R6 R7 flags", flags, VEC[v][4:0]);
        end

        // R3 writing zero leaves flags alone, writing one clears one flag
        reg_write(1'b0, 6'h00);
        chk("R3 write0", flags, 5'b01011);
        reg_write(1'b0, 6'h02);
        chk("R3 write1", flags, 5'b01001);

        // R1 short start glitch
        reg_write(1'b0, 6'h1F);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        chk("R1 glitch", flags, 5'b0);

        // R7 empty mask: any wake-up frame matches
        wake_mask = 8'h00;
        send_frame(8'h77, 1'b0, 1'b1, 1'b1, 1'b0);
        repeat (8) @(negedge clk);
        chk("R7 mask0", flags, 5'b10001);
        wake_mask = 8'hF0;

        // R8 R9 interrupt and DMA gating
        reg_write(1'b0, 6'h1F);
        reg_write(1'b1, 6'b000001);
        send_frame(8'h41, 1'b0, 1'b0, 1'b1, 1'b0);
        repeat (8) @(negedge clk);
        chk("R8 irq plain", irq, 1'b1);
        chk("R9 no dma", dma_req, 1'b0);
        reg_write(1'b1, 6'b000011);
        chk("R8 irq gated", irq, 1'b0);
        chk("R9 dma req", dma_req, 1'b1);
        dma_eop = 1'b1;
        @(negedge clk);
        chk("R8 irq eop", irq, 1'b1);
        dma_eop = 1'b0;
        reg_write(1'b0, 6'h01);
        chk("R9 dma drop", dma_req, 1'b0);

        // R4 R5 break, reported twice
        reg_write(1'b1, 6'b001000);
        send_frame(8'h41, 1'b0, 1'b0, 1'b1, 1'b0);
        repeat (8) @(negedge clk);
        reg_write(1'b0, 6'h1F);
        send_frame(8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        repeat (40) @(negedge clk);
        chk("R4 flags", flags, 5'b00100);
        chk("R4 irq", irq, 1'b1);
        chk("R4 rx_data kept", rx_data, 8'h41);
        reg_write(1'b0, 6'h04);
        chk("R3 brk cleared", flags, 5'b00000);
        chk("R8 irq off", irq, 1'b0);
        rxd = 1'b1;
        repeat (8) @(negedge clk);
        chk("R5 rx_data zero", rx_data, 8'h00);
        chk("R5 R6 flags", flags, 5'b01101);
        chk("R5 irq again", irq, 1'b1);

        // R10 set wins over a clear held during the event
        reg_write(1'b0, 6'h1F);
        wr_sel  = 1'b0;
        wr_data = 6'b001000;
        wr_en   = 1'b1;
        mon_on  = 1'b1;
        send_frame(8'h0D, 1'b0, 1'b0, 1'b1, 1'b0);
        repeat (8) @(negedge clk);
        wr_en  = 1'b0;
        mon_on = 1'b0;
        chk("R10 ctrl seen", ctrl_seen, 1'b1);
        chk("R10 flags after", flags, 5'b00001);

        summary();
        $finish;
    end

endmodule